// File: doc/BRIEF.md
# Boolean Pattern Match Engine

This block watches eight asynchronous input signals and evaluates a programmable sum-of-products expression over them. The expression is built from eight bit slices. Each slice observes one chosen input and tests it for a level or a transition. Runs of consecutive slices are ANDed into product terms (minterms). An endpoint flag on a slice closes the current minterm. Each closed minterm drives its own interrupt line. The OR of all minterms is the overall match. A rising match can raise a single-cycle receive-event pulse.

Software configures the engine through a plain write-only register port. Every write also re-arms the engine, which clears all latched edge detections. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. The inputs are level signals that are sampled on every clock, and the outputs are plain control lines.

Top module: `pattern_match_engine`

## Requirements
- R1: After reset, every minterm interrupt, the match output and the event pulse are 0, and every slice condition is "always false" (code 7).
- R2: Each slice observes the input whose index is held in its 3-bit select field. Slice i uses bits [3i+2:3i] of register 0.
- R3: Inputs pass through two synchronizing flops. Code 4 is true while the synchronized input is high, and code 5 is true while it is low.
- R4: Code 0 is always true and code 7 is always false, whatever the inputs do. Slice i's code sits in bits [3i+2:3i] of register 1.
- R5: Codes 1 (rising), 2 (falling) and 3 (either edge) become true in the cycle the synchronized edge is seen. They stay true until the next register write of any address, including address 3, which changes no setting.
- R6: Code 6 is true only in the single cycle in which the synchronized input differs from its previous sample.
- R7: Register 2 bits [7:0] mark endpoint slices, and slice 7 is always an endpoint. Minterm interrupt i is the AND of the slices that follow the previous endpoint, up to and including slice i. It is 0 on a slice that is not an endpoint.
- R8: The match output is the OR of all minterm interrupts.
- R9: When register 2 bit 8 is set, the event output pulses for exactly one cycle on each 0-to-1 transition of the match. When that bit is clear, the event output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Asynchronous inputs to the expression |
| cfg_we_i | input | 1 | Register write strobe; any write re-arms sticky edges |
| cfg_addr_i | input | 2 | 0 select, 1 condition codes, 2 endpoints and event enable, 3 re-arm only |
| cfg_wdata_i | input | 24 | Write data |
| term_irq_o | output | 8 | One interrupt per minterm, at its endpoint slice |
| match_o | output | 1 | OR of all minterms |
| rx_event_o | output | 1 | One-cycle pulse on a rising match, if enabled |

## Verification
The first sweep drives all 256 input values through alternating high and low slices, with each slice reading the input in mirrored order. This separates a wrong select decode from a wrong level polarity. The second sweep runs all 256 endpoint masks against three input patterns, which shows where minterms are cut and that slice 7 always closes a term. Directed sequences toggle one input under the rising, falling, either-edge and event codes. They tell sticky behaviour apart from one-cycle behaviour, and they show that the re-arm write clears the latch. They also check that the event pulse lasts one cycle and follows its enable bit.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int PME_N_IN    = 8;
  localparam int PME_N_SLICE = 8;
  localparam int PME_SEL_W   = $clog2(PME_N_IN);
  localparam int PME_CODE_W  = 3;

  typedef enum logic [PME_CODE_W-1:0] {
    COND_TRUE  = 3'd0,
    COND_RISE  = 3'd1,
    COND_FALL  = 3'd2,
    COND_BOTH  = 3'd3,
    COND_HIGH  = 3'd4,
    COND_LOW   = 3'd5,
    COND_EVENT = 3'd6,
    COND_FALSE = 3'd7
  } pme_cond_e;
endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_o  <= '0;
      prv_o  <= '0;
    end else begin
      meta_q <= d_i;
      cur_o  <= meta_q;
      prv_o  <= cur_o;
    end
  end
endmodule

// File: rtl/pme_slice.sv
module pme_slice
  import pme_pkg::*;
#(
  parameter int N_IN  = PME_N_IN,
  parameter int SEL_W = PME_SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rearm_i,
  input  logic [SEL_W-1:0] sel_i,
  input  pme_cond_e       code_i,
  input  logic [N_IN-1:0] cur_i,
  input  logic [N_IN-1:0] prv_i,
  output logic            hit_o,
  output logic            sticky_o
);
  logic now_v, old_v, rise, fall, catch_edge;

  always_comb begin
    now_v = cur_i[sel_i];
    old_v = prv_i[sel_i];
    rise  = now_v & ~old_v;
    fall  = ~now_v & old_v;
    catch_edge = 1'b0;
    hit_o = 1'b0;
    case (code_i)
      COND_TRUE:  hit_o = 1'b1;
      COND_RISE:  begin catch_edge = rise;        hit_o = sticky_o | rise; end
      COND_FALL:  begin catch_edge = fall;        hit_o = sticky_o | fall; end
      COND_BOTH:  begin catch_edge = rise | fall; hit_o = sticky_o | rise | fall; end
      COND_HIGH:  hit_o = now_v;
      COND_LOW:   hit_o = ~now_v;
      COND_EVENT: hit_o = rise | fall;
      default:    hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky_o <= 1'b0;
    else if (rearm_i) sticky_o <= 1'b0;
    else              sticky_o <= sticky_o | catch_edge;
  end
endmodule

// File: rtl/pme_combine.sv
module pme_combine #(
  parameter int N = 8
) (
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] ep_i,
  output logic [N-1:0] term_o
);
  logic [N-1:0] run;
  logic [N-1:0] ep_eff;

  assign ep_eff = {1'b1, ep_i[N-2:0]};
  assign run[0] = hit_i[0];

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign run[i] = hit_i[i] & (ep_eff[i-1] | run[i-1]);
  end

  assign term_o = run & ep_eff;
endmodule

// File: rtl/pattern_match_engine.sv
module pattern_match_engine
  import pme_pkg::*;
#(
  parameter int N_IN    = PME_N_IN,
  parameter int N_SLICE = PME_N_SLICE,
  parameter int SEL_W   = PME_SEL_W,
  parameter int CODE_W  = PME_CODE_W,
  parameter int DATA_W  = PME_N_SLICE * PME_CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    pins_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_wdata_i,
  output logic [N_SLICE-1:0] term_irq_o,
  output logic               match_o,
  output logic               rx_event_o
);
  localparam int SEL_BITS  = N_SLICE * SEL_W;
  localparam int CODE_BITS = N_SLICE * CODE_W;

  logic [SEL_BITS-1:0]  sel_q;
  logic [CODE_BITS-1:0] cond_q;
  logic [N_SLICE-1:0]   ep_q;
  logic                 evt_en_q;
  logic                 match_q;
  logic [N_IN-1:0]      cur, prv;
  logic [N_SLICE-1:0]   hit;
  logic [N_SLICE-1:0]   sticky_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      cond_q   <= '1;
      ep_q     <= '0;
      evt_en_q <= 1'b0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        2'd0:    sel_q  <= cfg_wdata_i[SEL_BITS-1:0];
        2'd1:    cond_q <= cfg_wdata_i[CODE_BITS-1:0];
        2'd2:    {evt_en_q, ep_q} <= cfg_wdata_i[N_SLICE:0];
        default: ;
      endcase
    end
  end

  pme_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .cur_o(cur), .prv_o(prv)
  );

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    pme_slice #(.N_IN(N_IN), .SEL_W(SEL_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .rearm_i  (cfg_we_i),
      .sel_i    (sel_q[i*SEL_W +: SEL_W]),
      .code_i   (pme_cond_e'(cond_q[i*CODE_W +: CODE_W])),
      .cur_i    (cur),
      .prv_i    (prv),
      .hit_o    (hit[i]),
      .sticky_o (sticky_vec[i])
    );
  end

  pme_combine #(.N(N_SLICE)) u_comb (
    .hit_i(hit), .ep_i(ep_q), .term_o(term_irq_o)
  );

  assign match_o = |term_irq_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_o;
  end

  assign rx_event_o = evt_en_q & match_o & ~match_q;
endmodule

// File: rtl/pme_checker.sv
module pme_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic         match,
  input logic         rx_event,
  input logic         evt_en,
  input logic [N-1:0] sticky
);
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> !rx_event); // R9
  AST_EVT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> (match && evt_en)); // R9
  AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(match) && evt_en) |-> rx_event); // R9
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (sticky == '0)); // R5
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((sticky & $past(sticky)) == $past(sticky))); // R5
endmodule

bind pattern_match_engine pme_checker #(.N(N_SLICE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_i), .match(match_o),
  .rx_event(rx_event_o), .evt_en(evt_en_q), .sticky(sticky_vec)
);

// File: tb/tb_pattern_match_engine.sv
module tb_pattern_match_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [7:0]  term;
  logic        match, rxev;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pattern_match_engine dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .term_irq_o(term), .match_o(match), .rx_event_o(rxev)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [23:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // edge reaches the slices after two rising edges; sample at the next falling edge
  task automatic to_edge();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] model(logic [7:0] p, logic [23:0] sel,
                                       logic [23:0] cond, logic [7:0] ep);
    logic [7:0] t;
    logic run;
    t = '0;
    run = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic s, h, e;
      s = p[sel[3*i +: 3]];
      case (cond[3*i +: 3])
        3'd0:    h = 1'b1;
        3'd4:    h = s;
        3'd5:    h = ~s;
        default: h = 1'b0;
      endcase
      run = run & h;
      e = ep[i] | (i == 7);
      t[i] = e & run;
      if (e) run = 1'b1;
    end
    return t;
  endfunction

  initial begin
    logic [23:0] sel_m, cond_a, ident, high_all;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", term, 8'h00);
    chk("R1 match/event", {6'b0, match, rxev}, 8'h00);

    // R4 constant codes
    wr(2, 24'h000000);
    wr(1, 24'h000000);
    settle();
    chk("R4 all true", term, 8'h80);
    wr(1, 24'hFFFFFF);
    pins = 8'hFF;
    settle();
    chk("R4 all false", term, 8'h00);

    // R2 R3 R7 R8: mirrored select, alternating high/low, pairs
    sel_m = '0; cond_a = '0; ident = '0; high_all = '0;
    for (int i = 0; i < 8; i++) begin
      sel_m[3*i +: 3]    = 3'(7 - i);
      cond_a[3*i +: 3]   = (i % 2 == 0) ? 3'd4 : 3'd5;
      ident[3*i +: 3]    = 3'(i);
      high_all[3*i +: 3] = 3'd4;
    end
    wr(0, sel_m);
    wr(1, cond_a);
    wr(2, 24'h00002A);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      pins = 8'(v);
      settle();
      e = model(8'(v), sel_m, cond_a, 8'h2A);
      chk("R2/R3 level sweep", term, e);
      chk("R8 match", {7'b0, match}, {7'b0, |e});
    end

    // R7 endpoint sweep
    wr(0, ident);
    wr(1, high_all);
    for (int m = 0; m < 256; m++) begin
      wr(2, 24'(m));
      for (int k = 0; k < 3; k++) begin
        logic [7:0] p;
        p = (k == 0) ? 8'hFF : (k == 1) ? 8'hF7 : 8'h7E;
        pins = p;
        settle();
        chk("R7 endpoints", term, model(p, ident, high_all, 8'(m)));
      end
    end

    // R5 sticky rising, slice 0 alone as a minterm, event enabled
    wr(0, 24'h0);
    wr(1, 24'hFFFFF9);
    wr(2, 24'h000101);
    pins = 8'h00;
    settle();
    wr(3, 24'h0);
    chk("R5 armed idle", term, 8'h00);
    pins = 8'h01;
    to_edge();
    chk("R5 rise seen", term, 8'h01);
    chk("R9 pulse", {7'b0, rxev}, 8'h01);
    @(negedge clk);
    chk("R5 rise held", term, 8'h01);
    chk("R9 one cycle", {7'b0, rxev}, 8'h00);
    pins = 8'h00;
    settle();
    chk("R5 held after fall", term, 8'h01);
    wr(3, 24'h0);
    chk("R5 re-arm clears", term, 8'h00);

    // R5 sticky falling
    wr(1, 24'hFFFFFA);
    pins = 8'h01;
    settle();
    chk("R5 fall ignores rise", term, 8'h00);
    pins = 8'h00;
    to_edge();
    chk("R5 fall seen", term, 8'h01);
    settle();
    chk("R5 fall held", term, 8'h01);

    // R5 either edge
    wr(1, 24'hFFFFFB);
    chk("R5 either armed", term, 8'h00);
    pins = 8'h01;
    to_edge();
    chk("R5 either seen", term, 8'h01);
    settle();
    chk("R5 either held", term, 8'h01);

    // R6 event code, non-sticky
    wr(1, 24'hFFFFFE);
    pins = 8'h00;
    to_edge();
    chk("R6 event cycle", term, 8'h01);
    @(negedge clk);
    chk("R6 event gone", term, 8'h00);

    // R9 enable clear: match rises, no pulse
    wr(2, 24'h000001);
    pins = 8'h01;
    to_edge();
    chk("R9 match w/o enable", {7'b0, match}, 8'h01);
    chk("R9 no pulse disabled", {7'b0, rxev}, 8'h00);
    @(negedge clk);
    chk("R9 still none", {7'b0, rxev}, 8'h00);

    summary();
  end
endmodule